// File: doc/BRIEF.md
# Dual-Channel Edge-Select Input Capture

This block copies the value of a free-running counter into one of two capture registers when a chosen edge appears on that channel's trigger input. It is used to time external events. Software reads two captured values and takes their difference to get a period or a pulse width. The counter, the bus decoding and any waveform generation sit outside the block. It receives the counter value, the counter's run signal and a mode bit that picks capture or comparator operation.

Each channel has its own 2-bit edge code, a capture-done flag, an overwrite flag and two interrupt enables. Every trigger input passes through a two-flop synchroniser and one history flop. Edges are decoded from the last two synchronised samples. A captured value whose flag has not been cleared can be replaced by a new capture; the overwrite flag records that this happened. The flags are cleared by write-one-to-clear strobes. The block drives a single combined interrupt request.

Top module: `input_capture_dual`

## Requirements
- R1: Edge code 0 disables the channel. Neither edge of its trigger causes a capture, and the channel's flags and data stay unchanged.
- R2: Edge code 1 captures on a low-to-high transition of the trigger only.
- R3: Edge code 2 captures on a high-to-low transition of the trigger only.
- R4: Edge code 3 captures on both transitions of the trigger.
- R5: The capture register loads the counter value present at the third rising clock edge after the trigger changes. That is two synchroniser stages plus the capture stage. The new value is visible after that edge.
- R6: The capture flag of a channel is set at the same clock edge at which its register loads.
- R7: If a capture occurs while the channel's capture flag is already 1, the register is overwritten and the overwrite flag of that channel is set.
- R8: When mode_capture is 0 (comparator operation), no capture, flag change or data change occurs on any channel, whatever the edge codes are.
- R9: When count_run is 0, no capture occurs.
- R10: Writing 1 to a bit of clr_cap or clr_ovf for one cycle clears that channel's flag at the next edge. If a set and a clear of the same flag fall in the same cycle, the flag ends up 1.
- R11: irq is 1 exactly when any channel has (capture flag AND cap_ie) or (overwrite flag AND ovf_ie). Bit 0 of each vector is channel A and bit 1 is channel B.
- R12: After reset, all flags, both capture registers and irq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_val | input | 16 | Current counter value |
| count_run | input | 1 | Counter running |
| mode_capture | input | 1 | 1 = capture operation, 0 = comparator operation |
| trig | input | 2 | Asynchronous trigger inputs, bit 0 = A, bit 1 = B |
| edge_sel_a | input | 2 | Edge code of channel A (0 none, 1 rise, 2 fall, 3 both) |
| edge_sel_b | input | 2 | Edge code of channel B |
| cap_ie | input | 2 | Capture interrupt enables |
| ovf_ie | input | 2 | Overwrite interrupt enables |
| clr_cap | input | 2 | Write-one-to-clear strobes for the capture flags |
| clr_ovf | input | 2 | Write-one-to-clear strobes for the overwrite flags |
| cap_data_a | output | 16 | Capture register A |
| cap_data_b | output | 16 | Capture register B |
| cap_flag | output | 2 | Capture-done flags |
| ovf_flag | output | 2 | Overwrite flags |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench covers both channels, all four edge codes and both transition directions. The resulting table of capture versus no capture separates rising, falling, both and none, and shows that one channel's code never affects the other. Each case loads a distinct counter value, so a late capture, an early capture or a capture on the wrong channel gives the wrong data. Separate patterns cover the following:
- repeated edges with the flag still set, which separates an overwrite from a fresh capture;
- a clear that arrives in the same cycle as a capture;
- comparator mode and a stopped counter;
- all sixteen enable combinations against a known set of flags.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_code_t;

  function automatic logic edge_match(input logic [1:0] code, input logic rise, input logic fall);
    logic r;
    case (code)
      EDGE_RISE: r = rise;
      EDGE_FALL: r = fall;
      EDGE_BOTH: r = rise | fall;
      default:   r = 1'b0;
    endcase
    return r;
  endfunction

  function automatic logic next_flag(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/cap_sync.sv
module cap_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic s1, s2, hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= 1'b0;
      s2   <= 1'b0;
      hist <= 1'b0;
    end else begin
      s1   <= din;
      s2   <= s1;
      hist <= s2;
    end
  end

  assign rise = s2 & ~hist;
  assign fall = ~s2 & hist;
endmodule

// File: rtl/cap_channel.sv
module cap_channel #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise,
  input  logic          fall,
  input  logic [1:0]    edge_sel,
  input  logic          allow,
  input  logic [CW-1:0] count_val,
  input  logic          clr_cap,
  input  logic          clr_ovf,
  output logic [CW-1:0] data,
  output logic          cap_flag,
  output logic          ovf_flag,
  output logic          hit
);
  import cap_pkg::*;

  logic overwrite;

  assign hit       = allow & edge_match(edge_sel, rise, fall);
  assign overwrite = hit & cap_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data     <= '0;
      cap_flag <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      if (hit) data <= count_val;
      cap_flag <= next_flag(cap_flag, hit, clr_cap);
      ovf_flag <= next_flag(ovf_flag, overwrite, clr_ovf);
    end
  end
endmodule

// File: rtl/input_capture_dual.sv
module input_capture_dual #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count_val,
  input  logic          count_run,
  input  logic          mode_capture,
  input  logic [1:0]    trig,
  input  logic [1:0]    edge_sel_a,
  input  logic [1:0]    edge_sel_b,
  input  logic [1:0]    cap_ie,
  input  logic [1:0]    ovf_ie,
  input  logic [1:0]    clr_cap,
  input  logic [1:0]    clr_ovf,
  output logic [CW-1:0] cap_data_a,
  output logic [CW-1:0] cap_data_b,
  output logic [1:0]    cap_flag,
  output logic [1:0]    ovf_flag,
  output logic          irq
);
  localparam int NCH = 2;

  logic [NCH-1:0]         rise, fall, hit;
  logic [NCH-1:0][1:0]    sel;
  logic [NCH-1:0][CW-1:0] data;
  logic                   allow;

  assign allow  = mode_capture & count_run;
  assign sel[0] = edge_sel_a;
  assign sel[1] = edge_sel_b;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    cap_sync u_sync (
      .clk(clk), .rst_n(rst_n), .din(trig[c]), .rise(rise[c]), .fall(fall[c])
    );
    cap_channel #(.CW(CW)) u_ch (
      .clk(clk), .rst_n(rst_n), .rise(rise[c]), .fall(fall[c]),
      .edge_sel(sel[c]), .allow(allow), .count_val(count_val),
      .clr_cap(clr_cap[c]), .clr_ovf(clr_ovf[c]), .data(data[c]),
      .cap_flag(cap_flag[c]), .ovf_flag(ovf_flag[c]), .hit(hit[c])
    );
  end

  assign cap_data_a = data[0];
  assign cap_data_b = data[1];
  assign irq = |((cap_flag & cap_ie) | (ovf_flag & ovf_ie));
endmodule

// File: rtl/input_capture_dual_chk.sv
module input_capture_dual_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] count_val,
  input logic          count_run,
  input logic          mode_capture,
  input logic [1:0]    clr_cap,
  input logic [1:0]    hit,
  input logic [CW-1:0] cap_data_a,
  input logic [1:0]    cap_flag,
  input logic [1:0]    ovf_flag,
  input logic          irq
);
  assert_data_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit[0] |=> cap_data_a == $past(count_val));
  assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit[0] |=> cap_flag[0]);
  assert_flag_set_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit[1] |=> cap_flag[1]);
  assert_overwrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit[0] && cap_flag[0]) |=> ovf_flag[0]);
  assert_no_cap_cmp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_capture |-> hit == 2'b00);
  assert_no_cap_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !count_run |-> hit == 2'b00);
  assert_flag_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit[0] && !clr_cap[0]) |=> $stable(cap_flag[0]));
  assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_flag == 2'b00 && ovf_flag == 2'b00) |-> !irq);
endmodule

bind input_capture_dual input_capture_dual_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .count_val(count_val), .count_run(count_run),
  .mode_capture(mode_capture), .clr_cap(clr_cap), .hit(hit),
  .cap_data_a(cap_data_a), .cap_flag(cap_flag), .ovf_flag(ovf_flag), .irq(irq)
);

// File: tb/test_input_capture_dual.sv
module test_input_capture_dual;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] count_val = '0;
  logic        count_run = 1'b0, mode_capture = 1'b0;
  logic [1:0]  trig = '0, edge_sel_a = '0, edge_sel_b = '0;
  logic [1:0]  cap_ie = '0, ovf_ie = '0, clr_cap = '0, clr_ovf = '0;
  logic [15:0] cap_data_a, cap_data_b;
  logic [1:0]  cap_flag, ovf_flag;
  logic        irq;

  int errors = 0, checks = 0;
  logic [15:0] exp_data [2];

  input_capture_dual i_input_capture_dual (.*);

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic set_sel(input int ch, input logic [1:0] code);
    if (ch == 0) edge_sel_a = code; else edge_sel_b = code;
  endtask

  function automatic logic [15:0] data_of(input int ch);
    return ch == 0 ? cap_data_a : cap_data_b;
  endfunction

  task automatic clear_all();
    @(negedge clk); clr_cap = 2'b11; clr_ovf = 2'b11;
    @(negedge clk); clr_cap = 2'b00; clr_ovf = 2'b00;
  endtask

  // Flip the trigger at a falling edge; the result is visible after the third rising edge.
  task automatic flip(input int ch);
    @(negedge clk); trig[ch] = ~trig[ch];
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    exp_data[0] = '0; exp_data[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 flags", {cap_flag, ovf_flag}, 0);
    check("R12 data", {cap_data_a, cap_data_b}, 0);
    check("R12 irq", irq, 0);

    mode_capture = 1'b1; count_run = 1'b1;
    // R1 R2 R3 R4 R5 R6: sweep channel x code x direction
    for (int ch = 0; ch < 2; ch++)
      for (int code = 0; code < 4; code++)
        for (int dir = 0; dir < 2; dir++) begin
          logic hit;
          logic [15:0] v;
          set_sel(ch, 2'd0);
          @(negedge clk); trig[ch] = dir[0];
          repeat (4) @(negedge clk);
          clear_all();
          set_sel(ch, code[1:0]);
          v = 16'h1000 * ch[15:0] + 16'h0100 * code[15:0] + 16'h0010 * dir[15:0] + 16'h5;
          count_val = v;
          flip(ch);
          hit = (code == 3) || (code == 1 && dir == 0) || (code == 2 && dir == 1);
          if (hit) exp_data[ch] = v;
          check($sformatf("R1/R2/R3/R4 flag ch%0d code%0d dir%0d", ch, code, dir), cap_flag, hit ? (2'b1 << ch) : 2'b00);
          check("R5 data", data_of(ch), exp_data[ch]);
          check("R5 other channel data", data_of(1 - ch), exp_data[1 - ch]);
          check("R7 no overwrite on first", ovf_flag, 0);
        end
    set_sel(1, 2'd0);

    // R7: second capture on channel A with its flag still set
    clear_all();
    set_sel(0, 2'd3);
    count_val = 16'hAAA1; flip(0);
    check("R6 first capture flag", cap_flag[0], 1);
    check("R7 before overwrite", ovf_flag[0], 0);
    count_val = 16'hAAA2; flip(0);
    check("R7 overwrite flag", ovf_flag[0], 1);
    check("R7 overwritten data", cap_data_a, 16'hAAA2);
    exp_data[0] = 16'hAAA2;

    // channel B captures once, with no overwrite
    set_sel(1, 2'd3);
    count_val = 16'hBBB1; flip(1);
    exp_data[1] = 16'hBBB1;
    check("R6 B flag", cap_flag, 2'b11);
    check("R7 B no overwrite", ovf_flag, 2'b01);

    // R11: flags are cap=11, ovf=01
    for (int e = 0; e < 16; e++) begin
      logic ex;
      @(negedge clk);
      cap_ie = e[1:0]; ovf_ie = e[3:2];
      #1;
      ex = (cap_ie[0] | cap_ie[1]) | ovf_ie[0];
      check($sformatf("R11 irq ie=%0h", e), irq, ex);
    end
    cap_ie = 0; ovf_ie = 0;

    // R10: write-one-to-clear of a single flag
    @(negedge clk); clr_cap = 2'b01;
    @(negedge clk); clr_cap = 2'b00;
    check("R10 cap A cleared", cap_flag, 2'b10);
    check("R10 ovf A kept", ovf_flag, 2'b01);
    @(negedge clk); clr_ovf = 2'b01;
    @(negedge clk); clr_ovf = 2'b00;
    check("R10 ovf A cleared", ovf_flag, 2'b00);

    // R10: set wins. Capture A again (flag 0 -> 1), then capture with a clear in the same cycle.
    count_val = 16'hC001; flip(0);
    @(negedge clk); trig[0] = ~trig[0]; count_val = 16'hC002;
    repeat (2) @(posedge clk);
    @(negedge clk); clr_cap = 2'b01;
    @(posedge clk);
    @(negedge clk); clr_cap = 2'b00;
    check("R10 set wins over clear", cap_flag[0], 1);
    check("R7 overwrite at clear cycle", ovf_flag[0], 1);
    check("R5 data at clear cycle", cap_data_a, 16'hC002);
    exp_data[0] = 16'hC002;

    // R8: comparator mode blocks capture
    clear_all();
    mode_capture = 1'b0;
    count_val = 16'hD00D; flip(0); flip(1);
    check("R8 no flags", {cap_flag, ovf_flag}, 0);
    check("R8 data A kept", cap_data_a, exp_data[0]);
    check("R8 data B kept", cap_data_b, exp_data[1]);

    // R9: stopped counter blocks capture
    mode_capture = 1'b1; count_run = 1'b0;
    count_val = 16'hE00E; flip(0); flip(1);
    check("R9 no flags", {cap_flag, ovf_flag}, 0);
    check("R9 data A kept", cap_data_a, exp_data[0]);
    check("R9 data B kept", cap_data_b, exp_data[1]);

    count_run = 1'b1;
    count_val = 16'hF00F; flip(1);
    check("R9 resumes", cap_data_b, 16'hF00F);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule